// File: doc/BRIEF.md
# Fixed-Interval Pulse Generator

This block turns the tick strobe of a nanosecond time counter into two periodic pulse trains. Each of the two channels holds a down-counter in nanoseconds. The counter is loaded with a programmed period and reduced by the tick period on every tick. When the remaining time falls below one tick, the channel fires and reloads. A period value of V therefore yields an interval of floor(V / TICK_NS) + 1 ticks. A value written as the wanted interval minus one tick lands exactly on that interval.

A shared prescale ratio defines an output clock as the tick rate divided by that ratio. Each pulse stays high for one output-clock period, which is the effective ratio counted in ticks. Channel A is normally set for one pulse per second. Channel B is set for a faster rate, such as 10 kHz. The period inputs are treated as live register values. Each channel takes its period value only when it reloads, so a running interval is never shortened by a write.

Top module: `interval_pulse_gen`

## Requirements
- R1: While `rstN` is low, both pulse outputs are low, and they stay low after reset for as long as `enable` is low.
- R2: When `enable` is low at a clock edge, both pulses are low from the next cycle on. The cycle in which `enable` is first seen high restarts each channel with its full period and does not count a tick.
- R3: Each qualified tick lowers the channel's remaining time by TICK_NS nanoseconds. The channel fires on the tick at which the remaining time is below TICK_NS, so a period value V gives floor(V / TICK_NS) + 1 ticks between pulse starts (V = 30 or 35 gives 4 ticks at TICK_NS = 10). A pulse rises only in the cycle after a tick.
- R4: A pulse rises in the cycle after its firing tick and stays high for W ticks, where W is the prescale ratio. It falls only in the cycle after a tick or after `enable` goes low.
- R5: A prescale ratio of 0 or 1 means no division, and the pulse lasts exactly one tick.
- R6: A period change that arrives in the middle of an interval leaves that interval unchanged. The new value governs the interval that starts at the next reload.
- R7: When a period change is present in the same cycle as a firing tick, the new value is used for the interval that starts at that reload.
- R8: The two channels count and fire independently, each from its own period input.
- R9: Without ticks, a channel does not count and its pulse output does not change.
- R10: If a channel fires again before its pulse has ended, the width count restarts and the pulse stays high without a gap.
- R11: A period of 99990 with a prescale ratio of 100 (10 ns ticks) gives pulses 10000 ticks apart that are 100 ticks wide, which is a 10 kHz train with 1 µs pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the generators; low clears them |
| tickStb | input | 1 | One-cycle strobe per tick of the time counter |
| prscRatio | input | PRSC_W | Prescale ratio, which is the pulse width in ticks |
| periodA | input | CNT_W | Channel A period in ns, minus one tick |
| periodB | input | CNT_W | Channel B period in ns, minus one tick |
| pulseA | output | 1 | Channel A pulse train |
| pulseB | output | 1 | Channel B pulse train |

## Verification
Two things can coincide in one cycle: a firing tick that reloads a channel, and a change of that channel's period input. The bench changes the period exactly one cycle before the firing edge. It then judges which value was used by where the next pulse starts. A change made earlier in the interval is checked the same way, and it must not move the pending pulse. A second case puts a re-fire inside a pulse that is still active, using an interval shorter than the width, and requires an output with no gap.

// File: rtl/ipg_pkg.sv
`timescale 1ns/1ps
package ipg_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic clear;  // generator disabled: wipe counters
    logic start;  // first enabled cycle: load full periods
    logic step;   // qualified tick: count down
  } ipgStrobe_t;

endpackage

// File: rtl/ipg_ctrl.sv
`timescale 1ns/1ps
module ipg_ctrl
  import ipg_pkg::*;
#(
  parameter int PRSC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              tickStb,
  input  logic [PRSC_W-1:0] prscRatio,
  output ipgStrobe_t        strobe,
  output logic [PRSC_W-1:0] widthTicks
);

  localparam logic [PRSC_W-1:0] RATIO_ONE = PRSC_W'(1);
  localparam logic [PRSC_W-1:0] RATIO_TWO = PRSC_W'(2);

  logic enableQ;

  always_ff @(posedge clk) begin
    if (!rstN) enableQ <= 1'b0;
    else       enableQ <= enable;
  end

  always_comb begin
    strobe.clear = !enable;
    strobe.start = enable && !enableQ;
    strobe.step  = enable && enableQ && tickStb;
  end

  // Ratios 0 and 1 both mean no division.
  assign widthTicks = (prscRatio < RATIO_TWO) ? RATIO_ONE : prscRatio;

endmodule

// File: rtl/ipg_datapath.sv
`timescale 1ns/1ps
module ipg_datapath
  import ipg_pkg::*;
#(
  parameter int NUM_GEN = 2,
  parameter int CNT_W   = 32,
  parameter int PRSC_W  = 16,
  parameter int TICK_NS = 10
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ipgStrobe_t                    strobe,
  input  logic [NUM_GEN-1:0][CNT_W-1:0] periodVec,
  input  logic [PRSC_W-1:0]             widthTicks,
  output logic [NUM_GEN-1:0]            pulse
);

  localparam logic [CNT_W-1:0]  TICK_STEP = CNT_W'(TICK_NS);
  localparam logic [PRSC_W-1:0] WIDTH_DEC = PRSC_W'(1);

  for (genvar g = 0; g < NUM_GEN; g++) begin : gen_chan
    logic [CNT_W-1:0]  remNs;
    logic [PRSC_W-1:0] widthLeft;
    logic              fire;

    // Fire when another decrement would go below zero.
    assign fire = strobe.step && (remNs < TICK_STEP);

    always_ff @(posedge clk) begin
      if (!rstN || strobe.clear) begin
        remNs     <= '0;
        widthLeft <= '0;
      end else if (strobe.start) begin
        remNs     <= periodVec[g];
        widthLeft <= '0;
      end else if (strobe.step) begin
        if (fire) begin
          // The period input is taken only here, at reload.
          remNs     <= periodVec[g];
          widthLeft <= widthTicks;
        end else begin
          remNs <= remNs - TICK_STEP;
          if (widthLeft != '0) widthLeft <= widthLeft - WIDTH_DEC;
        end
      end
    end

    assign pulse[g] = (widthLeft != '0);
  end

endmodule

// File: rtl/interval_pulse_gen.sv
`timescale 1ns/1ps
module interval_pulse_gen
  import ipg_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int PRSC_W  = 16,
  parameter int TICK_NS = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              tickStb,
  input  logic [PRSC_W-1:0] prscRatio,
  input  logic [CNT_W-1:0]  periodA,
  input  logic [CNT_W-1:0]  periodB,
  output logic              pulseA,
  output logic              pulseB
);

  localparam int NUM_GEN = 2;

  ipgStrobe_t                    strobe;
  logic [PRSC_W-1:0]             widthTicks;
  logic [NUM_GEN-1:0][CNT_W-1:0] periodVec;
  logic [NUM_GEN-1:0]            pulse;

  assign periodVec[0] = periodA;
  assign periodVec[1] = periodB;

  ipg_ctrl #(.PRSC_W(PRSC_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .tickStb    (tickStb),
    .prscRatio  (prscRatio),
    .strobe     (strobe),
    .widthTicks (widthTicks)
  );

  ipg_datapath #(
    .NUM_GEN (NUM_GEN),
    .CNT_W   (CNT_W),
    .PRSC_W  (PRSC_W),
    .TICK_NS (TICK_NS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .periodVec  (periodVec),
    .widthTicks (widthTicks),
    .pulse      (pulse)
  );

  assign pulseA = pulse[0];
  assign pulseB = pulse[1];

endmodule

// File: rtl/ipg_checker.sv
`timescale 1ns/1ps
module ipg_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic tickStb,
  input logic pulseA,
  input logic pulseB
);

  // R2
  off_low_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !pulseA);
  // R2
  off_low_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !pulseB);
  // R3
  rise_after_tick_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseA) |-> $past(tickStb));
  // R3
  rise_after_tick_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseB) |-> $past(tickStb));
  // R4
  fall_after_tick_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pulseA) |-> ($past(tickStb) || !$past(enable)));
  // R4
  fall_after_tick_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pulseB) |-> ($past(tickStb) || !$past(enable)));
  // R9
  idle_hold_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !tickStb) |=> $stable(pulseA));
  // R9
  idle_hold_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !tickStb) |=> $stable(pulseB));

endmodule

bind interval_pulse_gen ipg_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .enable  (enable),
  .tickStb (tickStb),
  .pulseA  (pulseA),
  .pulseB  (pulseB)
);

// File: tb/interval_pulse_gen_bench.sv
`timescale 1ns/1ps
module interval_pulse_gen_bench;

  localparam int CNT_W   = 32;
  localparam int PRSC_W  = 16;
  localparam int TICK_NS = 10;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              enable = 1'b0;
  logic              tickStb = 1'b1;
  logic [PRSC_W-1:0] prscRatio = '0;
  logic [CNT_W-1:0]  periodA = '0;
  logic [CNT_W-1:0]  periodB = '0;
  logic              pulseA, pulseB;

  int total = 0;
  int bad = 0;

  // Records from observe(): rise sample indices, first-pulse width, always-high flag.
  int riseIdx [2][3];
  int firstWidth [2];
  bit highAfterRise [2];

  always #2.5 clk = ~clk;

  interval_pulse_gen #(.CNT_W(CNT_W), .PRSC_W(PRSC_W), .TICK_NS(TICK_NS)) u_interval_pulse_gen (
    .clk(clk), .rstN(rstN), .enable(enable), .tickStb(tickStb),
    .prscRatio(prscRatio), .periodA(periodA), .periodB(periodB),
    .pulseA(pulseA), .pulseB(pulseB)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Disable for a cycle, then enable; the next edge is the start edge (index 0).
  task automatic restart();
    @(negedge clk) enable = 1'b0;
    @(negedge clk) enable = 1'b1;
  endtask

  // Sample n cycles after each edge; optionally change one period after sample chgAt.
  task automatic observe(input int n, input int chgAt, input int chgGen, input int chgVal);
    bit prev [2];
    bit inFirst [2];
    bit cur [2];
    int riseCnt [2];
    prev[0] = pulseA; prev[1] = pulseB;
    for (int g = 0; g < 2; g++) begin
      riseCnt[g] = 0; firstWidth[g] = 0; highAfterRise[g] = 1'b1; inFirst[g] = 1'b0;
      for (int r = 0; r < 3; r++) riseIdx[g][r] = -1;
    end
    for (int j = 0; j < n; j++) begin
      @(posedge clk);
      @(negedge clk);
      cur[0] = pulseA; cur[1] = pulseB;
      for (int g = 0; g < 2; g++) begin
        if (cur[g] && !prev[g]) begin
          if (riseCnt[g] < 3) riseIdx[g][riseCnt[g]] = j;
          if (riseCnt[g] == 0) inFirst[g] = 1'b1;
          riseCnt[g]++;
        end
        if (inFirst[g]) begin
          if (cur[g]) firstWidth[g]++;
          else inFirst[g] = 1'b0;
        end
        if (riseCnt[g] > 0 && !cur[g]) highAfterRise[g] = 1'b0;
        prev[g] = cur[g];
      end
      if (j == chgAt) begin
        if (chgGen == 0) periodA = CNT_W'(chgVal);
        else             periodB = CNT_W'(chgVal);
      end
    end
  endtask

  task automatic testReset();
    check("R1 pulseA in reset", int'(pulseA), 0);
    check("R1 pulseB in reset", int'(pulseB), 0);
    @(negedge clk) rstN = 1'b1;
    periodA = 30; periodB = 50; prscRatio = 2;
    observe(8, -1, 0, 0);
    check("R1 no pulseA while disabled", riseIdx[0][0], -1);
    check("R1 no pulseB while disabled", riseIdx[1][0], -1);
  endtask

  task automatic testBasic();
    periodA = 30; periodB = 50; prscRatio = 2;
    restart();
    observe(14, -1, 0, 0);
    check("R3 A first rise", riseIdx[0][0], 4);
    check("R3 A second rise", riseIdx[0][1], 8);
    check("R3 A third rise", riseIdx[0][2], 12);
    check("R4 A width ratio 2", firstWidth[0], 2);
    check("R8 B first rise", riseIdx[1][0], 6);
    check("R8 B second rise", riseIdx[1][1], 12);
  endtask

  task automatic testRatio();
    periodA = 30; periodB = 1000;
    prscRatio = 0; restart(); observe(8, -1, 0, 0);
    check("R5 width ratio 0", firstWidth[0], 1);
    prscRatio = 1; restart(); observe(8, -1, 0, 0);
    check("R5 width ratio 1", firstWidth[0], 1);
    prscRatio = 3; restart(); observe(8, -1, 0, 0);
    check("R4 width ratio 3", firstWidth[0], 3);
  endtask

  task automatic testRounding();
    periodA = 35; periodB = 1000; prscRatio = 1;
    restart(); observe(10, -1, 0, 0);
    check("R3 V=35 first rise", riseIdx[0][0], 4);
    check("R3 V=35 second rise", riseIdx[0][1], 8);
  endtask

  task automatic testMidChange();
    periodA = 50; periodB = 1000; prscRatio = 2;
    restart(); observe(12, 2, 0, 20);
    check("R6 interval not cut short", riseIdx[0][0], 6);
    check("R6 new value at next reload", riseIdx[0][1], 9);
  endtask

  task automatic testCollision();
    periodA = 30; periodB = 1000; prscRatio = 2;
    restart(); observe(14, 3, 0, 60);
    check("R7 first rise", riseIdx[0][0], 4);
    check("R7 change on firing cycle used", riseIdx[0][1], 11);
  endtask

  task automatic testDisable();
    periodA = 30; periodB = 50; prscRatio = 2;
    restart(); observe(5, -1, 0, 0);
    check("R2 pulse up before disable", int'(pulseA), 1);
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    check("R2 pulseA low after disable", int'(pulseA), 0);
    check("R2 pulseB low after disable", int'(pulseB), 0);
    @(negedge clk) enable = 1'b1;
    observe(10, -1, 0, 0);
    check("R2 restart full interval", riseIdx[0][0], 4);
  endtask

  task automatic testIdle();
    periodA = 30; periodB = 1000; prscRatio = 2;
    @(negedge clk) tickStb = 1'b0;
    restart(); observe(10, -1, 0, 0);
    check("R9 no pulse without ticks", riseIdx[0][0], -1);
    tickStb = 1'b1;
    observe(6, -1, 0, 0);
    check("R9 count resumes with ticks", riseIdx[0][0], 3);
  endtask

  task automatic testOverlap();
    periodA = 10; periodB = 1000; prscRatio = 3;
    restart(); observe(12, -1, 0, 0);
    check("R10 first rise", riseIdx[0][0], 2);
    check("R10 no gap when re-fired", int'(highAfterRise[0]), 1);
  endtask

  task automatic testTenKilo();
    periodA = 32'd200000000; periodB = 32'd99990; prscRatio = 100;
    restart(); observe(20010, -1, 0, 0);
    check("R11 first rise", riseIdx[1][0], 10000);
    check("R11 width 100 ticks", firstWidth[1], 100);
    check("R11 second rise", riseIdx[1][1], 20000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testBasic();
    testRatio();
    testRounding();
    testMidChange();
    testCollision();
    testDisable();
    testIdle();
    testOverlap();
    testTenKilo();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule